// File: doc/BRIEF.md
# I2S Audio Transceiver Controller

This block moves audio samples between a register bus and a three-wire serial audio link. Software writes samples into a transmit FIFO through one data port and reads received samples out of a receive FIFO through the same port. A serializer sends each sample MSB first in its channel slot. A deserializer rebuilds the incoming words and stores them. Either side of the link can generate the bit clock and the word-select line, or take them from outside through two-flop synchronisers.

The control register holds several settings. It picks 16- or 32-bit slots, which channel of a frame carries the first FIFO word, and the polarity of word-select. It also sets a FIFO service threshold for each direction, which drives status bits and the DMA request outputs, and it can loop the transmitted serial data back into the receiver. Transmit underrun and receive overrun are sticky. Each stays set until software writes one to its bit in a clear register. An interrupt line ORs every pending flag that the mask register allows.

Top module: `i2s_link_ctrl`

## Requirements
- R1: After reset the control (offset 0x00), disable (0x04) and mask (0x14) registers read 0, status (0x0C) reads 0x0000_0009, and irq is low.
- R2: A write to offset 0x80 appends the word to the TX FIFO when it holds fewer than DEPTH words and is ignored when it is full. Status bit 0 is "TX not full" and status bits 12:8 give the TX level.
- R3: A read of offset 0x80 returns the oldest RX word and removes it, or returns 0 when the RX FIFO is empty. Status bit 1 is "RX not empty" and status bits 20:16 give the RX level.
- R4: Control bit 2 makes the block drive the bit clock (sck_oe=1, sck_out toggles every CLK_HALF clk cycles). Control bit 1 makes it drive word-select (ws_oe=1). The driven word-select toggles once per slot, and only on a falling bit-clock edge. ws_out equals the channel (0 left, 1 right) XOR control bit 21.
- R5: With control bit 5 set, transmitted serial data feeds the receiver. Control bit 22 selects 32-bit slots (1) or 16-bit slots (0). Each word goes out MSB first, starting one bit clock after the word-select change. Received words equal the sent words in order; in 16-bit mode only the low 16 bits are carried and the upper bits read 0.
- R6: Control bit 24 = 0 places the first FIFO word in a left slot, and 1 places it in a right slot. Both paths start on a slot of that first channel.
- R7: When a slot starts on a running transmit path and the TX FIFO is empty, the block sends a zero word and sets sticky status bit 5 (underrun).
- R8: A received word that completes while the RX FIFO is full is dropped and sets sticky status bit 6 (overrun).
- R9: Writing 1 to bit 5 or bit 6 at offset 0x18 clears the matching sticky flag. A 0 in either bit leaves its flag unchanged.
- R10: TX service (status bit 3) is set when TX level <= control bits 12:8. RX service (status bit 4) is set when the RX level is nonzero and >= control bits 20:16. dma_tx_req is TX service AND control bit 3; dma_rx_req is RX service AND control bit 6.
- R11: irq is the OR of status bits 3 to 6, each ANDed with the same bit of the mask register.
- R12: Bit 1 at offset 0x04 stops the transmit path: no words are taken, zeros are sent, and no underrun is raised. Bit 0 stops the receive path: no words are stored and no overrun is raised.
- R13: Control bit 0 enables the link, and busy (status bit 2) equals bit 0 AND NOT bit 4. While control bit 4 is set, both FIFOs are empty and both sticky flags are clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX FIFO at 0x80) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| sck_in | input | 1 | External bit clock |
| sck_out | output | 1 | Generated bit clock |
| sck_oe | output | 1 | Bit clock output enable |
| ws_in | input | 1 | External word-select |
| ws_out | output | 1 | Generated word-select |
| ws_oe | output | 1 | Word-select output enable |
| sd_in | input | 1 | Serial data in |
| sd_out | output | 1 | Serial data out |
| dma_tx_req | output | 1 | TX FIFO DMA request |
| dma_rx_req | output | 1 | RX FIFO DMA request |
| irq | output | 1 | Interrupt request |

## Verification
A slot counter or channel tracker that drifts shows at once as words read back in the wrong order, or with bits shifted, on the first loopback frame. It also shows as a word-select edge that the bench sees away from a falling bit-clock edge. A wrong FIFO pointer or level is visible at the next status read, through the level fields, the not-full and not-empty bits and the service requests. Sticky flag logic that fails to set or to hold is caught within a few slots of the FIFO running dry or filling up, and the clear-register checks catch one that fails to clear.

// File: rtl/i2s_link_ctrl.sv
module i2s_link_ctrl #(
  parameter int DEPTH    = 16,
  parameter int CLK_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        sck_in,
  output logic        sck_out,
  output logic        sck_oe,
  input  logic        ws_in,
  output logic        ws_out,
  output logic        ws_oe,
  input  logic        sd_in,
  output logic        sd_out,
  output logic        dma_tx_req,
  output logic        dma_rx_req,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;
  localparam int CW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
  localparam logic [31:0] CTRL_MASK = 32'h017F_1F7F;

  logic [31:0] ctrl;
  logic [1:0]  dis;
  logic [6:3]  mask;
  logic        und, ovr;

  wire wr_ctrl = reg_wr && reg_addr == 8'h00;
  wire wr_dis  = reg_wr && reg_addr == 8'h04;
  wire wr_mask = reg_wr && reg_addr == 8'h14;
  wire wr_clr  = reg_wr && reg_addr == 8'h18;
  wire wr_data = reg_wr && reg_addr == 8'h80;
  wire rd_data = reg_rd && reg_addr == 8'h80;

  wire active  = ctrl[0] & ~ctrl[4];
  wire link_rst = ctrl[4];
  wire bits32  = ctrl[22];
  wire inv     = ctrl[21];
  wire first_ch = ctrl[24];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl <= '0; dis <= '0; mask <= '0;
    end else begin
      if (wr_ctrl) ctrl <= reg_wdata & CTRL_MASK;
      if (wr_dis)  dis  <= reg_wdata[1:0];
      if (wr_mask) mask <= reg_wdata[6:3];
    end

  // synchronisers for the external link pins
  logic [2:0] sck_s;
  logic [1:0] ws_s, sd_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s <= '0; ws_s <= '0; sd_s <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sck_in};
      ws_s  <= {ws_s[0], ws_in};
      sd_s  <= {sd_s[0], sd_in};
    end

  // bit clock generation and edge events
  logic [CW-1:0] div_cnt;
  logic          sck_q;
  wire tick = active && ctrl[2] && div_cnt == CW'(CLK_HALF - 1);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_cnt <= '0; sck_q <= 1'b0;
    end else if (!active || !ctrl[2]) begin
      div_cnt <= '0; sck_q <= 1'b0;
    end else if (tick) begin
      div_cnt <= '0; sck_q <= ~sck_q;
    end else
      div_cnt <= div_cnt + 1'b1;

  wire rise_ev = ctrl[2] ? (tick & ~sck_q) : (active & sck_s[1] & ~sck_s[2]);
  wire fall_ev = ctrl[2] ? (tick & sck_q)  : (active & ~sck_s[1] & sck_s[2]);

  // word-select generation: toggles once per slot on a falling edge
  logic [4:0] wcnt;
  logic       ws_gen;
  wire [4:0]  slot_last = bits32 ? 5'd31 : 5'd15;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wcnt <= '0; ws_gen <= 1'b0;
    end else if (!active) begin
      wcnt <= '0; ws_gen <= 1'b0;
    end else if (fall_ev) begin
      if (wcnt == slot_last) begin
        wcnt <= '0; ws_gen <= ~ws_gen;
      end else
        wcnt <= wcnt + 1'b1;
    end

  wire chan = ctrl[1] ? ws_gen : (ws_s[1] ^ inv);
  assign ws_out  = ws_gen ^ inv;
  assign ws_oe   = ctrl[1];
  assign sck_out = sck_q;
  assign sck_oe  = ctrl[2];

  // FIFO storage
  logic [31:0]   tx_mem [DEPTH];
  logic [31:0]   rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [LW-1:0] tx_lvl, rx_lvl;
  wire tx_full  = tx_lvl == LW'(DEPTH);
  wire rx_full  = rx_lvl == LW'(DEPTH);
  wire rx_empty = rx_lvl == '0;

  // serializer / deserializer state
  logic [31:0] tx_sh, rx_sh;
  logic        ws_last, chg, rx_sync, tx_sync;

  wire         tx_go    = !dis[1] && (tx_sync || chan == first_ch);
  wire         tx_slot  = fall_ev && chg && tx_go;
  wire         tx_pop   = tx_slot && tx_lvl != '0;
  wire         und_ev   = tx_slot && tx_lvl == '0;
  wire [31:0]  tx_word  = tx_mem[tx_rp];
  wire [31:0]  tx_load  = !tx_pop ? 32'b0 : bits32 ? tx_word : {tx_word[15:0], 16'b0};
  wire         rx_bit   = ctrl[5] ? tx_sh[31] : sd_s[1];
  wire [31:0]  rx_new   = {rx_sh[30:0], rx_bit};
  wire [31:0]  rx_word  = bits32 ? rx_new : {16'b0, rx_new[15:0]};
  wire         rx_done  = rise_ev && chan != ws_last && rx_sync && !dis[0];
  wire         rx_push  = rx_done && !rx_full;
  wire         ovr_ev   = rx_done && rx_full;
  wire         tx_wr    = wr_data && !tx_full;
  wire         rx_rd    = rd_data && !rx_empty;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ws_last <= 1'b0; chg <= 1'b0; rx_sh <= '0; rx_sync <= 1'b0;
      tx_sh <= '0; tx_sync <= 1'b0;
    end else if (!active) begin
      ws_last <= 1'b0; chg <= 1'b0; rx_sh <= '0; rx_sync <= 1'b0;
      tx_sh <= '0; tx_sync <= 1'b0;
    end else begin
      if (rise_ev) begin
        ws_last <= chan;
        chg     <= chan != ws_last;
        rx_sh   <= rx_new;
        if (chan != ws_last) rx_sync <= !dis[0] && (rx_sync || chan == first_ch);
      end
      if (fall_ev) begin
        if (chg) begin
          tx_sh   <= tx_load;
          tx_sync <= tx_go;
        end else
          tx_sh <= {tx_sh[30:0], 1'b0};
      end
    end

  assign sd_out = tx_sh[31];

  always_ff @(posedge clk) begin
    if (tx_wr)   tx_mem[tx_wp] <= reg_wdata;
    if (rx_push) rx_mem[rx_wp] <= rx_word;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_lvl <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_lvl <= '0;
    end else if (link_rst) begin
      tx_wp <= '0; tx_rp <= '0; tx_lvl <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_lvl <= '0;
    end else begin
      if (tx_wr)   tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_rd)   rx_rp <= rx_rp + 1'b1;
      tx_lvl <= tx_lvl + LW'(tx_wr) - LW'(tx_pop);
      rx_lvl <= rx_lvl + LW'(rx_push) - LW'(rx_rd);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      und <= 1'b0; ovr <= 1'b0;
    end else if (link_rst) begin
      und <= 1'b0; ovr <= 1'b0;
    end else begin
      und <= (und & ~(wr_clr & reg_wdata[5])) | und_ev;
      ovr <= (ovr & ~(wr_clr & reg_wdata[6])) | ovr_ev;
    end

  wire tx_svc = 32'(tx_lvl) <= 32'(ctrl[12:8]);
  wire rx_svc = !rx_empty && 32'(rx_lvl) >= 32'(ctrl[20:16]);
  assign dma_tx_req = ctrl[3] & tx_svc;
  assign dma_rx_req = ctrl[6] & rx_svc;
  assign irq = |({ovr, und, rx_svc, tx_svc} & mask);

  logic [31:0] status;
  always_comb begin
    status = '0;
    status[16 +: LW] = rx_lvl;
    status[8 +: LW]  = tx_lvl;
    status[6:0] = {ovr, und, rx_svc, tx_svc, active, !rx_empty, !tx_full};
  end

  always_comb
    case (reg_addr)
      8'h00:   reg_rdata = ctrl;
      8'h04:   reg_rdata = {30'b0, dis};
      8'h0C:   reg_rdata = status;
      8'h14:   reg_rdata = {25'b0, mask, 3'b0};
      8'h80:   reg_rdata = rx_empty ? 32'b0 : rx_mem[rx_rp];
      default: reg_rdata = 32'b0;
    endcase

  a_r2_tx_level_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data |=> tx_lvl <= $past(tx_lvl));
  a_r3_rx_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_lvl <= LW'(DEPTH));
  a_r4_ws_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    active && ctrl[1] && !fall_ev && !wr_ctrl |=> $stable(ws_out));
  a_r7_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    und && !link_rst && !(wr_clr && reg_wdata[5]) |=> und);
  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && !link_rst && !(wr_clr && reg_wdata[6]) |=> ovr);
  a_r12_replay_off_keeps_tx: assert property (@(posedge clk) disable iff (!rst_n)
    dis[1] && !link_rst && !wr_data |=> tx_lvl == $past(tx_lvl));
endmodule

// File: tb/i2s_link_ctrl_tb.sv
module i2s_link_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        sck_out, sck_oe, ws_out, ws_oe, sd_out;
  logic        dma_tx_req, dma_rx_req, irq;

  i2s_link_ctrl u_dut (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .sck_in(1'b0), .sck_out, .sck_oe, .ws_in(1'b0), .ws_out, .ws_oe,
    .sd_in(1'b0), .sd_out, .dma_tx_req, .dma_rx_req, .irq);

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  logic [31:0] exp_q[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  // driver: queue the expected received word, then write it
  task automatic drive_word(input logic [31:0] w, input bit b32);
    exp_q.push_back(b32 ? w : {16'b0, w[15:0]});
    bus_write(8'h80, w);
  endtask

  task automatic wait_rx(input int min_lvl);
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      bus_read(8'h0C, s);
      if (int'(s[20:16]) >= min_lvl) break;
    end
  endtask

  // monitor: pop received words and compare with the queue
  task automatic drain(input int n, input string req);
    logic [31:0] d, e;
    for (int i = 0; i < n; i++) begin
      wait_rx(1);
      bus_read(8'h80, d);
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hxxxx_xxxx;
      check(req, d, e);
    end
  endtask

  // capture of the word-select level at the first rising serial bit
  int arm_id = 0, seen_id = 0;
  logic cap_ws = 1'b0, sd_prev = 1'b0;
  always @(negedge clk) begin
    if (arm_id != seen_id && sd_out && !sd_prev) begin
      cap_ws  <= ws_out;
      seen_id <= arm_id;
    end
    sd_prev <= sd_out;
  end

  // word-select must only move when the bit clock falls
  bit chk_ws_en = 1'b0;
  int ws_viol = 0;
  logic ws_prev = 1'b0, sck_prev = 1'b0;
  always @(negedge clk) begin
    if (chk_ws_en && ws_out != ws_prev && !(sck_prev && !sck_out)) ws_viol <= ws_viol + 1;
    ws_prev  <= ws_out;
    sck_prev <= sck_out;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] s;
    int toggles;
    logic last;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(8'h00, s); check("R1 control", s, 32'h0);
    bus_read(8'h0C, s); check("R1 status", s, 32'h9);
    bus_read(8'h14, s); check("R1 mask", s, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R4 idle word-select with inversion
    bus_write(8'h00, 32'h0020_0002);
    check("R4 ws_oe", {31'b0, ws_oe}, 32'h1);
    check("R4 inverted idle ws", {31'b0, ws_out}, 32'h1);
    check("R4 sck_oe off", {31'b0, sck_oe}, 32'h0);

    // Loopback, 16-bit, left first, master, TX DMA, TX threshold 2
    bus_write(8'h00, 32'h0000_022E);
    drive_word(32'hFFFF_A5C3, 1'b0);
    drive_word(32'h0000_1234, 1'b0);
    drive_word(32'h0000_8001, 1'b0);
    drive_word(32'h0000_7FFE, 1'b0);
    bus_read(8'h0C, s); check("R2 level 4, not full", s, 32'h0000_0401);
    check("R10 tx dma idle above threshold", {31'b0, dma_tx_req}, 32'h0);
    arm_id = 1;
    bus_write(8'h00, 32'h0000_022F);
    chk_ws_en = 1'b1;
    repeat (10) @(negedge clk);
    toggles = 0; last = sck_out;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sck_out != last) toggles++;
      last = sck_out;
    end
    check("R4 sck toggles", toggles, 20);
    check("R13 busy", {31'b0, s[2]}, 32'h0);
    bus_read(8'h0C, s); check("R13 busy while enabled", {31'b0, s[2]}, 32'h1);
    drain(4, "R5 loopback 16-bit word");
    check("R6 first word left slot", {31'b0, seen_id == 1, cap_ws}, {30'b0, 2'b10});
    repeat (2500) @(negedge clk);
    bus_read(8'h0C, s);
    check("R7 underrun sticky", {31'b0, s[5]}, 32'h1);
    check("R8 overrun sticky", {31'b0, s[6]}, 32'h1);
    check("R8 rx level full", {27'b0, s[20:16]}, 32'd16);
    check("R10 tx dma at empty", {31'b0, dma_tx_req}, 32'h1);
    check("R4 ws only on falling edge", ws_viol, 0);
    chk_ws_en = 1'b0;
    bus_write(8'h00, 32'h0000_022E);
    bus_write(8'h14, 32'h0000_0060);
    check("R11 irq pending", {31'b0, irq}, 32'h1);
    bus_read(8'h80, s); check("R7 zero word after underrun", s, 32'h0);
    bus_write(8'h18, 32'h0000_0020);
    bus_read(8'h0C, s);
    check("R9 underrun cleared", {31'b0, s[5]}, 32'h0);
    check("R9 overrun kept", {31'b0, s[6]}, 32'h1);
    check("R11 irq still set", {31'b0, irq}, 32'h1);
    bus_write(8'h18, 32'h0000_0040);
    check("R11 irq cleared", {31'b0, irq}, 32'h0);
    bus_write(8'h00, 32'h0000_0010);
    bus_read(8'h0C, s); check("R13 reset empties FIFOs", s, 32'h9);
    bus_write(8'h00, 32'h0);

    // R12 replay disabled
    bus_write(8'h04, 32'h2);
    bus_write(8'h00, 32'h0000_0026);
    bus_write(8'h80, 32'h1111);
    bus_write(8'h80, 32'h2222);
    bus_write(8'h00, 32'h0000_0027);
    repeat (500) @(negedge clk);
    bus_read(8'h0C, s);
    check("R12 replay off keeps TX level", {27'b0, s[12:8]}, 32'd2);
    check("R12 replay off no underrun", {31'b0, s[5]}, 32'h0);
    bus_write(8'h00, 32'h0000_0010);
    bus_write(8'h00, 32'h0);

    // R12 record disabled
    bus_write(8'h04, 32'h1);
    bus_write(8'h00, 32'h0000_0026);
    bus_write(8'h80, 32'h3333);
    bus_write(8'h80, 32'h4444);
    bus_write(8'h00, 32'h0000_0027);
    repeat (500) @(negedge clk);
    bus_read(8'h0C, s);
    check("R12 record off stores nothing", {27'b0, s[20:16]}, 32'd0);
    check("R12 record off no overrun", {31'b0, s[6]}, 32'h0);
    check("R12 record off TX drained", {27'b0, s[12:8]}, 32'd0);
    bus_write(8'h00, 32'h0000_0010);
    bus_write(8'h00, 32'h0);
    bus_write(8'h04, 32'h0);

    // 32-bit, right first, RX threshold 2 with RX DMA
    bus_write(8'h00, 32'h0142_0066);
    drive_word(32'hDEAD_BEEF, 1'b1);
    drive_word(32'h1234_5678, 1'b1);
    drive_word(32'h8000_0001, 1'b1);
    arm_id = 2;
    bus_write(8'h00, 32'h0142_0067);
    wait_rx(2);
    bus_read(8'h0C, s);
    check("R10 rx service", {31'b0, s[4]}, 32'h1);
    check("R10 rx dma", {31'b0, dma_rx_req}, 32'h1);
    drain(3, "R5 loopback 32-bit word");
    check("R6 first word right slot", {31'b0, seen_id == 2, cap_ws}, {30'b0, 2'b11});
    bus_write(8'h00, 32'h0000_0010);
    bus_write(8'h00, 32'h0);

    // R2 full FIFO drops writes, R3 empty read
    for (int i = 0; i < 17; i++) bus_write(8'h80, 32'(i));
    bus_read(8'h0C, s);
    check("R2 full not-full flag", {31'b0, s[0]}, 32'h0);
    check("R2 full level", {27'b0, s[12:8]}, 32'd16);
    bus_read(8'h80, s); check("R3 empty read", s, 32'h0);
    bus_read(8'h0C, s); check("R3 not-empty clear", {31'b0, s[1]}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule